// File: doc/BRIEF.md
# Serial Controller Control-Word Sequencer

This block is the register front end of a serial communications controller. A CPU reaches it through a two-address port. Address bit 0 low selects the data register, which the CPU reads for received characters and writes for characters to transmit. Address bit 0 high selects the control register, which the CPU writes with control words and reads for status. The upper address bits are ignored, so every address pair reaches the same block.

The meaning of a control write depends on where the block is in its set-up sequence:

- The first control write after a reset is a mode word.
- In synchronous mode, one or two sync characters follow the mode word. In asynchronous mode, none follow.
- Every later control write is a command word.
- A command with its internal-reset bit set starts the sequence again.

The block decodes the mode fields, holds the command bits and sync characters, and keeps the transmit-ready and receive-ready handshake flags. The serial shift engines sit outside the block. They connect through a load strobe with a data byte on the transmit side and a receive strobe with a character on the receive side.

Top module: `usart_ctrl_seq`

## Requirements
- R1: After reset, `seq_state` is 0 (expecting a mode word), `tx_rdy` and `rx_rdy` are 0, and a status read returns 8'h00.
- R2: The first control write after a reset is taken as the mode word. Its fields are decoded as follows: bits[1:0] give the baud factor (00 = sync, 01 = x1, 10 = x16, 11 = x64); bits[3:2] give the character length code (length = 5 + code); bit 4 is parity enable; bit 5 selects even parity; bits[7:6] hold the stop-bit or sync options.
- R3: In sync mode, the control writes that follow the mode word fill the sync characters. When mode bit 7 is 1 there is one sync character; when it is 0 there are two. `seq_state` codes are 1 = first sync character, 2 = second sync character, 3 = command.
- R4: In async mode, the control write that follows the mode word is already a command word (`seq_state` goes from 0 to 3).
- R5: A command write with bit 6 set returns `seq_state` to 0. Its other bits are ignored: the held command clears to 8'h00 and `tx_rdy` drops.
- R6: `tx_rdy` (status bit 0) stays 0 until the first command word that follows the mode and sync words has been written. After that it equals command bit 0 (transmit enable) while the transmit holding register is empty. A data write clears `tx_rdy`, and a `tx_done` strobe sets it again.
- R7: A `rx_strobe` sets `rx_rdy` (status bit 1) only while command bit 2 (receive enable) is set and set-up is complete. A data read clears `rx_rdy`.
- R8: In a received byte, the bits above the programmed character length read as zero.
- R9: Only address bit 0 is decoded (0 = data, 1 = control/status). Higher address bits have no effect.
- R10: Data writes made before set-up is complete produce no `tx_load` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | ADDR_W | CPU address; bit 0 selects data or control |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data (received byte or status) |
| tx_load | output | 1 | Pulse: hand a character to the transmit engine |
| tx_data | output | 8 | Character for the transmit engine |
| tx_done | input | 1 | Transmit engine has taken the held character |
| rx_strobe | input | 1 | Receive engine has a character ready |
| rx_char | input | 8 | Character from the receive engine |
| seq_state | output | 2 | Set-up position: 0 mode, 1 sync 1, 2 sync 2, 3 command |
| cfg_baud | output | 2 | Decoded baud factor field (00 = sync) |
| cfg_len | output | 2 | Character length code |
| cfg_par_en | output | 1 | Parity enable |
| cfg_par_even | output | 1 | Even parity select |
| cfg_opt | output | 2 | Stop-bit or sync options field |
| sync_char1 | output | 8 | First sync character |
| sync_char2 | output | 8 | Second sync character |
| cmd_word | output | 8 | Held command bits |
| tx_rdy | output | 1 | Transmit-ready flag |
| rx_rdy | output | 1 | Receive-ready flag |

## Verification
The assertions assume that `cpu_wr` and `cpu_rd` are never high in the same cycle. They also assume that the transmit engine raises `tx_done` only while a character is held, and that `rx_strobe` is a single-cycle pulse. The stimulus drives every CPU access as a one-cycle strobe on the falling clock edge. It raises `tx_done` only after a data write has cleared `tx_rdy`, and it never overlaps a receive strobe with a data read. Under these conditions the priority cases inside the flag logic never arise, so the properties about clearing and setting flags are checked against a single cause at a time.

// File: rtl/usart_seq_pkg.sv
package usart_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_MODE  = 2'd0,
    SEQ_SYNC1 = 2'd1,
    SEQ_SYNC2 = 2'd2,
    SEQ_CMD   = 2'd3
  } seq_state_e;

  // Packed so that the member order matches mode-word bits 7..0.
  typedef struct packed {
    logic [1:0] opt;       // [7:6] stop bits (async) or sync options
    logic       par_even;  // [5]
    logic       par_en;    // [4]
    logic [1:0] len_code;  // [3:2] length = 5 + code
    logic [1:0] baud;      // [1:0] 00 = sync
  } mode_word_t;

  localparam int CMD_TX_EN = 0;
  localparam int CMD_RX_EN = 2;
  localparam int CMD_IR    = 6;

  // Mask keeping only the bits of a character of the coded length.
  function automatic logic [7:0] len_mask(input logic [1:0] code);
    len_mask = 8'hFF >> (2'd3 - code);
  endfunction

  function automatic logic mode_is_async(input mode_word_t m);
    mode_is_async = (m.baud != 2'b00);
  endfunction

  // In sync mode, option bit 7 set means a single sync character.
  function automatic logic mode_single_sync(input mode_word_t m);
    mode_single_sync = m.opt[1];
  endfunction

endpackage

// File: rtl/usart_word_seq.sv
module usart_word_seq
  import usart_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] wdata,
  output seq_state_e state_o,
  output mode_word_t mode_o,
  output logic [7:0] sync1_o,
  output logic [7:0] sync2_o,
  output logic       init_done_o,
  output logic       cmd_wr_o,
  output logic       ir_o
);

  seq_state_e state_q, state_d;
  mode_word_t mode_q;
  mode_word_t wmode;
  logic [7:0] sync1_q, sync2_q;
  logic       done_q;

  assign wmode    = mode_word_t'(wdata);
  assign ir_o     = ctl_wr && (state_q == SEQ_CMD) && wdata[CMD_IR];
  assign cmd_wr_o = ctl_wr && (state_q == SEQ_CMD) && !wdata[CMD_IR];

  always_comb begin
    state_d = state_q;
    if (ctl_wr) begin
      unique case (state_q)
        SEQ_MODE:  state_d = mode_is_async(wmode) ? SEQ_CMD : SEQ_SYNC1;
        SEQ_SYNC1: state_d = mode_single_sync(mode_q) ? SEQ_CMD : SEQ_SYNC2;
        SEQ_SYNC2: state_d = SEQ_CMD;
        SEQ_CMD:   state_d = wdata[CMD_IR] ? SEQ_MODE : SEQ_CMD;
        default:   state_d = SEQ_MODE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_MODE;
      mode_q  <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ctl_wr && state_q == SEQ_MODE)  mode_q  <= wmode;
      if (ctl_wr && state_q == SEQ_SYNC1) sync1_q <= wdata;
      if (ctl_wr && state_q == SEQ_SYNC2) sync2_q <= wdata;
      if (ir_o)          done_q <= 1'b0;
      else if (cmd_wr_o) done_q <= 1'b1;
    end
  end

  assign state_o     = state_q;
  assign mode_o      = mode_q;
  assign sync1_o     = sync1_q;
  assign sync2_o     = sync2_q;
  assign init_done_o = done_q;

  // R4: an async mode word leads straight to command expectation
  a_r4_async_skips_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && state_q == SEQ_MODE && wdata[1:0] != 2'b00) |=> (state_q == SEQ_CMD));

  // R3: single-sync mode takes exactly one sync character
  a_r3_single_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && state_q == SEQ_SYNC1 && mode_q.opt[1]) |=> (state_q == SEQ_CMD));

  // R5: internal reset returns the sequencer to mode expectation
  a_r5_ir_back_to_mode: assert property (@(posedge clk) disable iff (!rst_n)
    ir_o |=> (state_q == SEQ_MODE && !done_q));

endmodule

// File: rtl/usart_hs_flags.sv
module usart_hs_flags
  import usart_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic       ir,
  input  logic       init_done,
  input  logic [1:0] len_code,
  input  logic [7:0] wdata,
  input  logic       data_wr,
  input  logic       data_rd,
  input  logic       tx_done,
  input  logic       rx_strobe,
  input  logic [7:0] rx_char,
  output logic [7:0] cmd_o,
  output logic       tx_rdy_o,
  output logic       rx_rdy_o,
  output logic [7:0] rx_buf_o,
  output logic       tx_load_o,
  output logic [7:0] tx_data_o
);

  logic [7:0] cmd_q, rx_buf_q;
  logic       tx_full_q, rx_full_q;
  logic       rx_take;

  assign tx_load_o = data_wr && init_done;
  assign tx_data_o = wdata;
  assign rx_take   = rx_strobe && init_done && cmd_q[CMD_RX_EN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      tx_full_q <= 1'b0;
      rx_full_q <= 1'b0;
      rx_buf_q  <= '0;
    end else if (ir) begin
      cmd_q     <= '0;
      tx_full_q <= 1'b0;
      rx_full_q <= 1'b0;
    end else begin
      if (cmd_wr) cmd_q <= wdata;
      if (tx_load_o)    tx_full_q <= 1'b1;
      else if (tx_done) tx_full_q <= 1'b0;
      if (rx_take) begin
        rx_buf_q  <= rx_char & len_mask(len_code);
        rx_full_q <= 1'b1;
      end else if (data_rd) begin
        rx_full_q <= 1'b0;
      end
    end
  end

  assign cmd_o    = cmd_q;
  assign tx_rdy_o = init_done && cmd_q[CMD_TX_EN] && !tx_full_q;
  assign rx_rdy_o = rx_full_q;
  assign rx_buf_o = rx_buf_q;

  // R6: loading a character drops transmit-ready
  a_r6_load_clears_txrdy: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load_o && !ir) |=> !tx_rdy_o);

  // R7: a data read with no new character drops receive-ready
  a_r7_read_clears_rxrdy: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !rx_strobe) |=> !rx_rdy_o);

  // R10: no character reaches the transmit engine before set-up completes
  a_r10_no_early_load: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !$past(cmd_wr) && !init_done) |-> !tx_load_o);

endmodule

// File: rtl/usart_ctrl_seq.sv
module usart_ctrl_seq
  import usart_seq_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              tx_load,
  output logic [7:0]        tx_data,
  input  logic              tx_done,
  input  logic              rx_strobe,
  input  logic [7:0]        rx_char,
  output logic [1:0]        seq_state,
  output logic [1:0]        cfg_baud,
  output logic [1:0]        cfg_len,
  output logic              cfg_par_en,
  output logic              cfg_par_even,
  output logic [1:0]        cfg_opt,
  output logic [7:0]        sync_char1,
  output logic [7:0]        sync_char2,
  output logic [7:0]        cmd_word,
  output logic              tx_rdy,
  output logic              rx_rdy
);

  localparam int SEL_BIT = 0;

  logic       sel_ctl;
  logic       ctl_wr, data_wr, data_rd;
  logic       init_done, cmd_wr_evt, ir_evt;
  seq_state_e st;
  mode_word_t mode;
  logic [7:0] rx_buf;
  logic [7:0] status;
  logic       unused_addr_hi;

  generate
    if (ADDR_W > 1) begin : g_alias
      assign unused_addr_hi = ^cpu_addr[ADDR_W-1:1];
    end else begin : g_noalias
      assign unused_addr_hi = 1'b0;
    end
  endgenerate

  assign sel_ctl = cpu_addr[SEL_BIT];
  assign ctl_wr  = cpu_wr &&  sel_ctl;
  assign data_wr = cpu_wr && !sel_ctl;
  assign data_rd = cpu_rd && !sel_ctl;

  usart_word_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr      (ctl_wr),
    .wdata       (cpu_wdata),
    .state_o     (st),
    .mode_o      (mode),
    .sync1_o     (sync_char1),
    .sync2_o     (sync_char2),
    .init_done_o (init_done),
    .cmd_wr_o    (cmd_wr_evt),
    .ir_o        (ir_evt)
  );

  usart_hs_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr_evt),
    .ir        (ir_evt),
    .init_done (init_done),
    .len_code  (mode.len_code),
    .wdata     (cpu_wdata),
    .data_wr   (data_wr),
    .data_rd   (data_rd),
    .tx_done   (tx_done),
    .rx_strobe (rx_strobe),
    .rx_char   (rx_char),
    .cmd_o     (cmd_word),
    .tx_rdy_o  (tx_rdy),
    .rx_rdy_o  (rx_rdy),
    .rx_buf_o  (rx_buf),
    .tx_load_o (tx_load),
    .tx_data_o (tx_data)
  );

  assign status    = {6'b0, rx_rdy, tx_rdy};
  assign cpu_rdata = sel_ctl ? status : rx_buf;

  assign seq_state    = st;
  assign cfg_baud     = mode.baud;
  assign cfg_len      = mode.len_code;
  assign cfg_par_en   = mode.par_en;
  assign cfg_par_even = mode.par_even;
  assign cfg_opt      = mode.opt;

  // R8: a 5-bit character never shows high bits on a data read
  a_r8_short_char_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && rx_rdy && mode.len_code == 2'b00) |-> (cpu_rdata[7:5] == 3'b000));

endmodule

// File: tb/usart_ctrl_seq_bench.sv
module usart_ctrl_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0]    cpu_wdata = '0;
  logic [7:0]    cpu_rdata;
  logic          tx_load;
  logic [7:0]    tx_data;
  logic          tx_done = 1'b0, rx_strobe = 1'b0;
  logic [7:0]    rx_char = '0;
  logic [1:0]    seq_state, cfg_baud, cfg_len, cfg_opt;
  logic          cfg_par_en, cfg_par_even;
  logic [7:0]    sync_char1, sync_char2, cmd_word;
  logic          tx_rdy, rx_rdy;

  int checks = 0, failures = 0, loads = 0;
  logic [7:0] last_tx = '0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  usart_ctrl_seq #(.ADDR_W(AW)) u_usart_ctrl_seq (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .tx_load(tx_load), .tx_data(tx_data),
    .tx_done(tx_done), .rx_strobe(rx_strobe), .rx_char(rx_char), .seq_state(seq_state),
    .cfg_baud(cfg_baud), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_par_even(cfg_par_even), .cfg_opt(cfg_opt), .sync_char1(sync_char1),
    .sync_char2(sync_char2), .cmd_word(cmd_word), .tx_rdy(tx_rdy), .rx_rdy(rx_rdy)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: a quarter period after each falling edge, inputs are settled.
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (tx_load) begin
      loads++;
      last_tx = tx_data;
    end
    if (cpu_rd) begin
      if (exp_q.size() == 0) begin
        check("scoreboard underflow", 8'h01, 8'h00);
      end else begin
        check(tag_q.pop_front(), cpu_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic rx_in(input logic [7:0] c);
    @(negedge clk);
    rx_char = c; rx_strobe = 1'b1;
    @(negedge clk);
    rx_strobe = 1'b0;
  endtask

  task automatic tx_take();
    @(negedge clk);
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
  endtask

  // Bench's own view of the length mask: 5 + code bits.
  function automatic logic [7:0] keep_bits(input logic [7:0] c, input int code);
    int n = 5 + code;
    keep_bits = c & 8'((16'd1 << n) - 16'd1);
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 seq_state", {6'b0, seq_state}, 8'd0);
    check("R1 flags", {6'b0, rx_rdy, tx_rdy}, 8'd0);
    bus_rd(2'd1, 8'h00, "R1 status read");

    // R10 data write before set-up
    bus_wr(2'd0, 8'h55);
    check("R10 no early load", 8'(loads), 8'd0);

    // R2/R4 async mode: x16, 7 bits, parity even, opt 11
    bus_wr(2'd1, 8'hFA);
    check("R2 baud", {6'b0, cfg_baud}, 8'd2);
    check("R2 len", {6'b0, cfg_len}, 8'd2);
    check("R2 parity", {6'b0, cfg_par_en, cfg_par_even}, 8'd3);
    check("R2 opt", {6'b0, cfg_opt}, 8'd3);
    check("R4 async to command", {6'b0, seq_state}, 8'd3);
    check("R6 tx_rdy before command", {7'b0, tx_rdy}, 8'd0);

    bus_wr(2'd1, 8'h05);
    check("R6 tx_rdy after command", {7'b0, tx_rdy}, 8'd1);
    check("R6 cmd_word", cmd_word, 8'h05);
    bus_rd(2'd1, 8'h01, "R6 status tx bit");

    // R9 alias address 2 is data
    bus_wr(2'd2, 8'hC3);
    check("R9 load via alias", 8'(loads), 8'd1);
    check("R9 load data", last_tx, 8'hC3);
    check("R6 tx_rdy after load", {7'b0, tx_rdy}, 8'd0);
    tx_take();
    check("R6 tx_rdy after done", {7'b0, tx_rdy}, 8'd1);

    // R7/R8 receive 7-bit character
    rx_in(8'hFF);
    check("R7 rx_rdy set", {7'b0, rx_rdy}, 8'd1);
    bus_rd(2'd3, 8'h03, "R9 status via alias");
    bus_rd(2'd0, keep_bits(8'hFF, 2), "R8 7-bit masked");
    check("R7 rx_rdy cleared", {7'b0, rx_rdy}, 8'd0);

    // R7 receiver disabled ignores strobe
    bus_wr(2'd1, 8'h01);
    rx_in(8'h12);
    check("R7 strobe ignored", {7'b0, rx_rdy}, 8'd0);

    // R5 internal reset with other bits set
    bus_wr(2'd1, 8'h45);
    check("R5 back to mode", {6'b0, seq_state}, 8'd0);
    check("R5 cmd cleared", cmd_word, 8'h00);
    check("R5 tx_rdy dropped", {7'b0, tx_rdy}, 8'd0);

    // R3 sync, double sync characters, 8 bits
    bus_wr(2'd1, 8'h0C);
    check("R3 to sync1", {6'b0, seq_state}, 8'd1);
    bus_wr(2'd1, 8'h16);
    check("R3 to sync2", {6'b0, seq_state}, 8'd2);
    check("R3 sync1 value", sync_char1, 8'h16);
    bus_wr(2'd1, 8'h27);
    check("R3 to command", {6'b0, seq_state}, 8'd3);
    check("R3 sync2 value", sync_char2, 8'h27);
    bus_wr(2'd1, 8'h04);
    check("R6 tx disabled", {7'b0, tx_rdy}, 8'd0);
    rx_in(8'hAB);
    bus_rd(2'd0, keep_bits(8'hAB, 3), "R8 8-bit full");

    // R3 single sync, 5 bits
    bus_wr(2'd1, 8'h40);
    bus_wr(2'd1, 8'h80);
    bus_wr(2'd1, 8'h33);
    check("R3 single sync to command", {6'b0, seq_state}, 8'd3);
    check("R3 single sync value", sync_char1, 8'h33);
    bus_wr(2'd1, 8'h05);
    rx_in(8'hFF);
    bus_rd(2'd0, keep_bits(8'hFF, 0), "R8 5-bit masked");

    repeat (2) @(negedge clk);
    check("scoreboard drained", 8'(exp_q.size()), 8'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule